// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller watches a vector of level-sensitive interrupt request lines. Each line has an 8-bit priority, and a lower number means more urgent. Each line also has an enable bit. A 3-bit split value divides every priority into two parts:

- the upper bits form the preempting group;
- the lower bits form a sub-priority that only orders pending requests within one group.

When the controller takes a request, it records the priority and line number on an active-priority stack. After a fixed entry delay it pulses a start strobe to the core. The entry on top of the stack is the current execution priority. A pending request preempts the running handler only when its group is strictly more urgent than the group on top of the stack.

When the core reports that a handler has finished, the controller first checks for an eligible request. If one is more urgent than the level the core would fall back to, the controller swaps it into the finished handler's stack slot. It then starts that handler after a shorter tail delay, and the interrupted context is never resumed in between. If no such request exists, the controller pops the stack and pulses a resume strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the nesting depth is 0, `exec_valid`, `hdl_start` and `resume` are low, all enables are clear, and a raised request produces no start.
- R2: With `cfg_sel`=0, `cfg_data` sets the priority of line `cfg_idx`. Among eligible requests, the smallest priority value is taken, and equal priorities go to the lowest line number.
- R3: With `cfg_sel`=2, `cfg_data[2:0]`=s makes the low s priority bits sub-priority, so the group is the priority shifted right by s. A pending request preempts only if its group is strictly below the group of the stack top.
- R4: `hdl_start` is a one-cycle pulse that rises exactly ENTRY_LAT (12) clock edges after the edge that takes a request from a non-exiting state. It carries the taken line on `hdl_id`, which also equals `exec_id` at that moment.
- R5: If an eligible request exists when `hdl_exit` is seen, the controller tail-chains to it. The request must either be more urgent in group than the stack entry beneath the top, or no entry may lie beneath. On a tail chain the top entry is replaced, the depth is unchanged, no `resume` pulse occurs, and `hdl_start` rises TAIL_LAT (6) edges later.
- R6: If `hdl_exit` is seen with no request qualifying for a tail chain, the stack pops and `resume` pulses for one cycle one edge later.
- R7: When the nesting depth equals STACK_DEPTH, no further request is taken, however urgent.
- R8: With `cfg_sel`=1, `cfg_data[0]` is the enable of line `cfg_idx`. A disabled request is never selected, and it is taken once enabled if still raised.
- R9: A line whose handler is on the stack is not taken again while its request stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 priority, 1 enable, 2 split |
| cfg_idx | input | IDX_W | Line number for priority and enable writes |
| cfg_data | input | 8 | Write data |
| irq_req | input | NUM_IRQ | Level request lines |
| hdl_exit | input | 1 | Core reports the current handler finished |
| hdl_start | output | 1 | One-cycle strobe: enter handler now |
| hdl_id | output | IDX_W | Line whose handler is being entered |
| resume | output | 1 | One-cycle strobe: return to the interrupted context |
| exec_valid | output | 1 | At least one handler is active |
| exec_id | output | IDX_W | Line on top of the active stack |
| exec_prio | output | 8 | Priority on top of the active stack |
| nest_depth | output | CNT_W | Number of active handlers |

## Verification
The hardest state to reach from the ports is a tail chain taken or refused at a full stack. In that case the exiting handler's neighbour beneath decides the outcome, not the exiting handler itself. The bench builds it by raising requests of steadily falling priority, one after each start. It then raises a more urgent request that must be held off, and retires the top handler so that the held request tail-chains in. A second case nests two handlers with a weaker request pending, where the exit must pop rather than chain. A sweep over all eight split values with a fixed pair of priorities crosses the preemption boundary at the split where the two groups become equal.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int PRIO_W  = 8;
  localparam int SPLIT_W = 3;

  typedef enum logic [1:0] {
    CFG_PRIO  = 2'd0,
    CFG_EN    = 2'd1,
    CFG_SPLIT = 2'd2
  } cfg_sel_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  function automatic logic [PRIO_W-1:0] group_of(input logic [PRIO_W-1:0] p,
                                                 input logic [SPLIT_W-1:0] s);
    return p >> s;
  endfunction

endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [1:0]                       cfg_sel,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [PRIO_W-1:0]                cfg_data,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_o,
  output logic [NUM_IRQ-1:0]               en_o,
  output logic [SPLIT_W-1:0]               split_o
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic hit;
    assign hit = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        prio_o[i] <= '0;
        en_o[i]   <= 1'b0;
      end else if (hit) begin
        if (cfg_sel == CFG_PRIO) prio_o[i] <= cfg_data;
        if (cfg_sel == CFG_EN)   en_o[i]   <= cfg_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) split_o <= '0;
    else if (cfg_we && cfg_sel == CFG_SPLIT) split_o <= cfg_data[SPLIT_W-1:0];
  end

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  input  logic [NUM_IRQ-1:0]             elig_i,
  output logic                           win_v,
  output logic [IDX_W-1:0]               win_id,
  output logic [PRIO_W-1:0]              win_prio
);

  // Ascending scan with strict compare keeps the lowest index on a full tie.
  always_comb begin
    win_v    = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig_i[i] && (!win_v || prio_i[i] < win_prio)) begin
        win_v    = 1'b1;
        win_id   = IDX_W'(i);
        win_prio = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              repl,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic [IDX_W-1:0]  in_id,
  output logic [CNT_W-1:0]  count,
  output logic [PRIO_W-1:0] top_prio,
  output logic [IDX_W-1:0]  top_id,
  output logic [PRIO_W-1:0] below_prio
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [IDX_W-1:0]  id_mem   [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [AW-1:0]     top_idx, below_idx, wr_idx;

  always_comb begin
    top_idx   = (cnt_q == '0) ? '0 : AW'(cnt_q - 1'b1);
    below_idx = (cnt_q < CNT_W'(2)) ? '0 : AW'(cnt_q - CNT_W'(2));
    wr_idx    = push ? AW'(cnt_q) : top_idx;
  end

  // Storage carries no reset so it can map onto distributed or block RAM.
  always_ff @(posedge clk) begin
    if (push || repl) begin
      prio_mem[wr_idx] <= in_prio;
      id_mem[wr_idx]   <= in_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (push) cnt_q <= cnt_q + 1'b1;
    else if (pop)  cnt_q <= cnt_q - 1'b1;
  end

  assign count      = cnt_q;
  assign top_prio   = prio_mem[top_idx];
  assign top_id     = id_mem[top_idx];
  assign below_prio = prio_mem[below_idx];

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int STACK_DEPTH = 8,
  parameter int ENTRY_LAT   = 12,
  parameter int TAIL_LAT    = 6,
  parameter int IDX_W       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  parameter int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [7:0]         cfg_data,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               hdl_exit,
  output logic               hdl_start,
  output logic [IDX_W-1:0]   hdl_id,
  output logic               resume,
  output logic               exec_valid,
  output logic [IDX_W-1:0]   exec_id,
  output logic [7:0]         exec_prio,
  output logic [CNT_W-1:0]   nest_depth
);

  localparam int LAT_MAX = (ENTRY_LAT > TAIL_LAT) ? ENTRY_LAT : TAIL_LAT;
  localparam int LW      = $clog2(LAT_MAX + 1);

  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_IRQ-1:0]             en_q;
  logic [SPLIT_W-1:0]             split_q;
  logic [NUM_IRQ-1:0]             active_q, active_nxt, elig;
  logic                           c_v;
  logic [IDX_W-1:0]               c_id;
  logic [PRIO_W-1:0]              c_prio;
  logic [CNT_W-1:0]               depth;
  logic [PRIO_W-1:0]              top_prio, below_prio;
  logic [IDX_W-1:0]               top_id;
  seq_state_e                     state_q;
  logic [LW-1:0]                  wait_q;
  logic                           idle, exit_ok, can_pre, chain;
  logic                           do_push, do_pop, do_repl;

  prio_irq_cfg #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .prio_o(prio_q), .en_o(en_q), .split_o(split_q)
  );

  assign elig = irq_req & en_q & ~active_q;

  prio_irq_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_pick (
    .prio_i(prio_q), .elig_i(elig),
    .win_v(c_v), .win_id(c_id), .win_prio(c_prio)
  );

  prio_irq_stack #(.DEPTH(STACK_DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_stack (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .repl(do_repl),
    .in_prio(c_prio), .in_id(c_id), .count(depth),
    .top_prio(top_prio), .top_id(top_id), .below_prio(below_prio)
  );

  // Decision logic: exit has precedence over a fresh take in the same cycle.
  always_comb begin
    idle    = (state_q == SEQ_IDLE);
    exit_ok = hdl_exit && (depth != '0);
    can_pre = c_v && (depth < CNT_W'(STACK_DEPTH)) &&
              ((depth == '0) || (group_of(c_prio, split_q) < group_of(top_prio, split_q)));
    chain   = exit_ok && c_v &&
              ((depth == CNT_W'(1)) ||
               (group_of(c_prio, split_q) < group_of(below_prio, split_q)));
    do_repl = idle && chain;
    do_pop  = idle && exit_ok && !chain;
    do_push = idle && !exit_ok && can_pre;
  end

  always_comb begin
    active_nxt = active_q;
    if (do_pop || do_repl)  active_nxt[top_id] = 1'b0;
    if (do_push || do_repl) active_nxt[c_id]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) active_q <= '0;
    else     active_q <= active_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      wait_q    <= '0;
      hdl_start <= 1'b0;
      hdl_id    <= '0;
      resume    <= 1'b0;
    end else begin
      hdl_start <= 1'b0;
      resume    <= do_pop;
      if (do_push || do_repl) begin
        state_q <= SEQ_WAIT;
        wait_q  <= do_push ? LW'(ENTRY_LAT - 1) : LW'(TAIL_LAT - 1);
        hdl_id  <= c_id;
      end else if (state_q == SEQ_WAIT) begin
        if (wait_q == '0) begin
          hdl_start <= 1'b1;
          state_q   <= SEQ_IDLE;
        end else begin
          wait_q <= wait_q - 1'b1;
        end
      end
    end
  end

  assign exec_valid = (depth != '0);
  assign exec_id    = top_id;
  assign exec_prio  = top_prio;
  assign nest_depth = depth;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 4,
  parameter int STACK_DEPTH = 8,
  parameter int ENTRY_LAT   = 12,
  parameter int TAIL_LAT    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             hdl_start,
  input logic [IDX_W-1:0] hdl_id,
  input logic             resume,
  input logic             exec_valid,
  input logic [IDX_W-1:0] exec_id,
  input logic [7:0]       exec_prio,
  input logic [CNT_W-1:0] nest_depth,
  input logic [2:0]       split,
  input logic             push,
  input logic             repl
);

  logic [15:0] since_q;
  logic        tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      tail_q  <= 1'b0;
    end else if (push) begin
      since_q <= 16'd1;
      tail_q  <= 1'b0;
    end else if (repl) begin
      since_q <= 16'd1;
      tail_q  <= 1'b1;
    end else if (since_q != 16'd0 && since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  AST_ENTRY_LATENCY: assert property (@(posedge clk) disable iff (rst)
    hdl_start |-> since_q == (tail_q ? 16'(TAIL_LAT + 1) : 16'(ENTRY_LAT + 1))); // R4

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    hdl_start |=> !hdl_start); // R4

  AST_START_IS_TOP: assert property (@(posedge clk) disable iff (rst)
    hdl_start |-> exec_valid && exec_id == hdl_id); // R4

  AST_PREEMPT_GROUP: assert property (@(posedge clk) disable iff (rst)
    (nest_depth == CNT_W'($past(nest_depth) + 1'b1) && $past(exec_valid) && $stable(split))
      |-> (exec_prio >> split) < ($past(exec_prio) >> split)); // R3

  AST_CHAIN_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (rst)
    repl |=> nest_depth == $past(nest_depth) && !resume); // R5

  AST_RESUME_POPS: assert property (@(posedge clk) disable iff (rst)
    resume |-> nest_depth == CNT_W'($past(nest_depth) - 1'b1)); // R6

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    nest_depth <= CNT_W'(STACK_DEPTH)); // R7

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .STACK_DEPTH(STACK_DEPTH),
  .ENTRY_LAT(ENTRY_LAT), .TAIL_LAT(TAIL_LAT)
) u_chk (
  .clk(clk), .rst(rst), .hdl_start(hdl_start), .hdl_id(hdl_id),
  .resume(resume), .exec_valid(exec_valid), .exec_id(exec_id),
  .exec_prio(exec_prio), .nest_depth(nest_depth), .split(split_q),
  .push(do_push), .repl(do_repl)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  localparam int N     = 10;
  localparam int DEP   = 4;
  localparam int ELAT  = 12;
  localparam int TLAT  = 6;
  localparam int IW    = $clog2(N);
  localparam int CW    = $clog2(DEP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0]    cfg_data = '0;
  logic [N-1:0]  irq_req = '0;
  logic          hdl_exit = 1'b0;
  logic          hdl_start, resume, exec_valid;
  logic [IW-1:0] hdl_id, exec_id;
  logic [7:0]    exec_prio;
  logic [CW-1:0] nest_depth;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .STACK_DEPTH(DEP), .ENTRY_LAT(ELAT), .TAIL_LAT(TLAT)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .irq_req(irq_req), .hdl_exit(hdl_exit),
    .hdl_start(hdl_start), .hdl_id(hdl_id), .resume(resume),
    .exec_valid(exec_valid), .exec_id(exec_id), .exec_prio(exec_prio),
    .nest_depth(nest_depth)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = IW'(idx); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_start(input int maxc, output int id, output int k);
    id = -1; k = 0;
    while (k < maxc) begin
      @(negedge clk);
      k++;
      if (hdl_start) begin
        id = int'(hdl_id);
        break;
      end
    end
  endtask

  task automatic do_exit(output bit res);
    hdl_exit = 1'b1;
    @(negedge clk);
    hdl_exit = 1'b0;
    res = resume;
  endtask

  task automatic cleanup();
    irq_req = '0;
    repeat (40) begin
      @(negedge clk);
      hdl_exit = (nest_depth != '0);
    end
    hdl_exit = 1'b0;
    @(negedge clk);
  endtask

  function automatic int pval(input int i);
    return ((i % 3) << 6) | ((i % 2) << 3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int id, k, w, l;
    bit res, exp_pre;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(nest_depth == 0, "R1 depth", int'(nest_depth), 0);
    check(!exec_valid && !hdl_start && !resume, "R1 outputs", int'(exec_valid), 0);
    irq_req = N'(1);
    wait_start(25, id, k);
    check(id == -1, "R1 enables clear", id, -1);
    irq_req = '0;

    for (int i = 0; i < N; i++) cfg_write(1, i, 1);
    cfg_write(2, 0, 0);
    for (int i = 0; i < N; i++) cfg_write(0, i, pval(i));

    // R2/R4/R5/R6 pair sweep
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (pval(j) < pval(i) || (pval(j) == pval(i) && j < i)) begin w = j; l = i; end
        else begin w = i; l = j; end
        irq_req = (N'(1) << i) | (N'(1) << j);
        wait_start(40, id, k);
        check(id == w, "R2 winner", id, w);
        check(k == ELAT + 1, "R4 entry latency", k, ELAT + 1);
        irq_req[w] = 1'b0;
        do_exit(res);
        if (i != j) begin
          check(res == 1'b0, "R5 no resume on chain", int'(res), 0);
          wait_start(20, id, k);
          check(id == l, "R5 chained id", id, l);
          check(k == TLAT, "R5 tail latency", k, TLAT);
          irq_req = '0;
          do_exit(res);
        end
        check(res == 1'b1, "R6 resume", int'(res), 1);
        check(nest_depth == 0, "R6 depth", int'(nest_depth), 0);
      end
    end

    // R3 split sweep: line 2 = 0x50 active, line 5 = 0x48 arrives
    cfg_write(0, 2, 8'h50);
    cfg_write(0, 5, 8'h48);
    for (int g = 0; g < 8; g++) begin
      cfg_write(2, 0, g);
      irq_req = N'(1) << 2;
      wait_start(40, id, k);
      check(id == 2, "R3 first handler", id, 2);
      irq_req[5] = 1'b1;
      exp_pre = ((8'h48 >> g) < (8'h50 >> g));
      wait_start(30, id, k);
      if (exp_pre) begin
        check(id == 5 && k == ELAT + 1, "R3 preempt", id, 5);
        check(nest_depth == 2, "R3 depth 2", int'(nest_depth), 2);
      end else begin
        check(id == -1, "R3 R9 no preempt or re-entry", id, -1);
        check(nest_depth == 1, "R3 depth 1", int'(nest_depth), 1);
      end
      cleanup();
    end
    cfg_write(2, 0, 0);

    // R8 enable gating
    cfg_write(0, 3, 8'h10);
    cfg_write(1, 3, 0);
    irq_req = N'(1) << 3;
    wait_start(30, id, k);
    check(id == -1, "R8 disabled ignored", id, -1);
    check(nest_depth == 0, "R8 depth", int'(nest_depth), 0);
    cfg_write(1, 3, 1);
    wait_start(30, id, k);
    check(id == 3, "R8 taken once enabled", id, 3);
    cleanup();

    // R7 full stack, then R5 chain from a full stack
    cfg_write(0, 9, 8'hC0);
    cfg_write(0, 8, 8'h80);
    cfg_write(0, 7, 8'h40);
    cfg_write(0, 6, 8'h20);
    cfg_write(0, 4, 8'h00);
    for (int n = 9; n >= 6; n--) begin
      irq_req[n] = 1'b1;
      wait_start(40, id, k);
      check(id == n, "R7 nest step", id, n);
    end
    check(nest_depth == DEP, "R7 full", int'(nest_depth), DEP);
    irq_req[4] = 1'b1;
    wait_start(30, id, k);
    check(id == -1, "R7 no take when full", id, -1);
    check(nest_depth == DEP, "R7 depth held", int'(nest_depth), DEP);
    irq_req[6] = 1'b0;
    do_exit(res);
    check(res == 1'b0, "R5 chain at full", int'(res), 0);
    wait_start(20, id, k);
    check(id == 4 && k == TLAT, "R5 chain id at full", id, 4);
    check(nest_depth == DEP, "R5 depth kept", int'(nest_depth), DEP);
    cleanup();

    // R6 chain refused: weaker pending than the entry beneath
    cfg_write(0, 1, 8'h10);
    cfg_write(0, 2, 8'h08);
    cfg_write(0, 3, 8'h30);
    irq_req = N'(1) << 1;
    wait_start(40, id, k);
    irq_req[2] = 1'b1;
    wait_start(40, id, k);
    check(id == 2, "R6 setup preempt", id, 2);
    irq_req[3] = 1'b1;
    irq_req[2] = 1'b0;
    do_exit(res);
    check(res == 1'b1, "R6 pop instead of chain", int'(res), 1);
    check(nest_depth == 1 && exec_id == 1, "R6 back to line 1", int'(nest_depth), 1);
    cleanup();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule